// File: doc/BRIEF.md
# Audio Serial Transmit Serializer

This block turns parallel audio samples into a three-wire serial audio stream: a word-select line, a data line and an externally supplied bit-clock enable (`bitTick`). Samples are pulled from a show-ahead FIFO read port. They go out most significant bit first, one bit clock after each word-select edge, which is the usual two-channel serial audio timing. Word select is low for the left channel and high for the right.

A single synchronous configuration write port controls the channel. It sets the sample width in whole bytes and chooses stereo or mono. It picks whether word select is generated here (master) or taken from an external line (slave), and it holds the master half-period. Three more fields are a mute, a stop that both mutes and freezes the FIFO, and a channel clear. The clear resets the channel asynchronously and is brought out so that it also empties the FIFO. When a sample falls due and the FIFO is empty, the block sends zeros for that half-frame and flags an underrun.

Top module: `aud_tx_serializer`

## Requirements
- R1: The configuration word fields are: width code in bits [1:0], mono in bit 2, stop in bit 3, channel clear in bit 4, slave select in bit 5, mute in bit 6, and half-period minus one in bits [15:7]. Reset loads width code 1, stereo, no stop, no clear, slave, mute on and half-period 31. After reset `wsOut` is 1, `sdOut` is 0, and in slave mode `wsOut` follows `wsIn`.
- R2: A width code c gives a sample of 8*(c+1) bits, so 0, 1, 2 and 3 mean 8, 16, 24 and 32 bits. The sample is taken from the low bits of the FIFO word and is sent most significant bit first.
- R3: In master mode `wsOut` changes only on a `bitTick`, and it toggles every half-period+1 ticks. It is 1 out of reset, so the first half-frame is the left one (`wsOut` low).
- R4: The first bit of a sample appears on the tick after the word-select change. Once the sample's bits are used up, the data line stays 0 until the next half-frame.
- R5: In stereo mode each half-frame consumes one FIFO word. The left word is sent while `wsOut` is 0 and the right word while it is 1.
- R6: In mono mode one FIFO word is read in the left half-frame and the same sample is sent again in the right half-frame.
- R7: Mute forces `sdOut` to 0, while FIFO reads carry on as normal.
- R8: Stop forces `sdOut` to 0, blocks all FIFO reads and raises no underrun.
- R9: If the FIFO is empty when a sample is due, zeros go out for that half-frame. `underrun` then pulses high for exactly one clock cycle.
- R10: In slave mode `wsIn` passes through a two-stage synchronizer. Each change seen on a tick starts the next half-frame, and the half-period field has no effect.
- R11: While the channel clear is 1, `fifoClear` is 1, `wsOut` is held at 1, `sdOut` is 0 and no reads occur. Once the clear is released, the channel restarts from its reset phase.
- R12: `fifoRdEn` is asserted only during a `bitTick` cycle and only when `fifoEmpty` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 16 | Configuration word |
| bitTick | input | 1 | One-cycle strobe per serial bit period |
| wsIn | input | 1 | External word select (slave mode) |
| wsOut | output | 1 | Word select in use |
| sdOut | output | 1 | Serial data |
| fifoRdEn | output | 1 | FIFO pop strobe |
| fifoRdData | input | 32 | FIFO head word (show-ahead) |
| fifoEmpty | input | 1 | FIFO empty flag |
| fifoClear | output | 1 | FIFO flush request, follows channel clear |
| underrun | output | 1 | One-cycle pulse: sample due while FIFO empty |

## Verification
There are two coincidences to check. With 32-bit samples and a 64-tick frame, the last bit of one sample goes out on the same tick that word select flips. The next sample's first bit then follows on the very next tick. The bench compares every tick against a model computed from the requirements, so a one-tick slip in either the edge or the load is caught. A shortened FIFO makes a word-select edge fall due against an empty FIFO in the same cycle that a read would have happened. The bench judges this by the read count, the underrun count and a check that no pulse lasts two cycles.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int HALF_W = 9;
  localparam int CFG_W  = 7 + HALF_W;

  typedef struct packed {
    logic [HALF_W-1:0] halfLen;
    logic              mute;
    logic              slave;
    logic              clear;
    logic              halt;
    logic              mono;
    logic [1:0]        widthCode;
  } cfg_t;

  typedef struct packed {
    logic step;   // shift one bit
    logic load;   // start of a sample slot
    logic fetch;  // load from FIFO head
    logic dry;    // sample due, FIFO empty
    logic reuse;  // mono right half: resend held word
  } strobe_t;
endpackage

// File: rtl/aud_tx_cfg.sv
module aud_tx_cfg
  import aud_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrData,
  output cfg_t             cfg
);
  localparam cfg_t CFG_RESET = '{halfLen: HALF_W'(31), mute: 1'b1, slave: 1'b1,
                                 clear: 1'b0, halt: 1'b0, mono: 1'b0, widthCode: 2'd1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfg <= CFG_RESET;
    else if (wrEn) cfg <= cfg_t'(wrData);
  end
endmodule

// File: rtl/aud_tx_ctrl.sv
module aud_tx_ctrl
  import aud_tx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    chanRstN,
  input  logic    bitTick,
  input  cfg_t    cfg,
  input  logic    wsIn,
  input  logic    fifoEmpty,
  output logic    wsOut,
  output strobe_t stb
);
  logic [SYNC_STAGES-1:0] wsSyncQ;
  logic [HALF_W-1:0]      halfCnt;
  logic wsCur, wsNext, wsSync, halfDone, loadPending, loadNow, needNew;

  assign wsSync   = wsSyncQ[SYNC_STAGES-1];
  assign halfDone = halfCnt >= cfg.halfLen;

  always_comb begin
    if (cfg.slave)     wsNext = wsSync;
    else if (halfDone) wsNext = ~wsCur;
    else               wsNext = wsCur;
  end

  always_ff @(posedge clk or negedge chanRstN) begin
    if (!chanRstN) wsSyncQ <= '1;
    else           wsSyncQ <= {wsSyncQ[SYNC_STAGES-2:0], wsIn};
  end

  always_ff @(posedge clk or negedge chanRstN) begin
    if (!chanRstN) begin
      wsCur       <= 1'b1;
      halfCnt     <= '0;
      loadPending <= 1'b0;
    end else if (bitTick) begin
      wsCur       <= wsNext;
      loadPending <= wsNext != wsCur;
      halfCnt     <= (cfg.slave || halfDone) ? '0 : halfCnt + 1'b1;
    end
  end

  assign loadNow = bitTick & loadPending;
  assign needNew = ~cfg.mono | ~wsCur;

  always_comb begin
    stb.step  = bitTick & ~loadPending;
    stb.load  = loadNow;
    stb.fetch = loadNow & ~cfg.halt & needNew & ~fifoEmpty;
    stb.dry   = loadNow & ~cfg.halt & needNew & fifoEmpty;
    stb.reuse = loadNow & ~cfg.halt & ~needNew;
  end

  assign wsOut = wsCur;
endmodule

// File: rtl/aud_tx_dp.sv
module aud_tx_dp
  import aud_tx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              chanRstN,
  input  cfg_t              cfg,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] fifoRdData,
  output logic              sdOut,
  output logic              underrun
);
  logic [DATA_W-1:0] shiftQ, holdQ;

  function automatic logic [DATA_W-1:0] alignWord(input logic [DATA_W-1:0] w,
                                                   input logic [1:0] code);
    int unsigned bits;
    bits = 8 * (int'(code) + 1);
    return w << (DATA_W - bits);
  endfunction

  always_ff @(posedge clk or negedge chanRstN) begin
    if (!chanRstN) begin
      shiftQ   <= '0;
      holdQ    <= '0;
      underrun <= 1'b0;
    end else begin
      underrun <= stb.dry;
      if (stb.load) begin
        if (stb.fetch) begin
          shiftQ <= alignWord(fifoRdData, cfg.widthCode);
          holdQ  <= fifoRdData;
        end else if (stb.reuse) begin
          shiftQ <= alignWord(holdQ, cfg.widthCode);
        end else begin
          shiftQ <= '0;
          if (stb.dry) holdQ <= '0;
        end
      end else if (stb.step) begin
        shiftQ <= {shiftQ[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign sdOut = shiftQ[DATA_W-1] & ~cfg.mute & ~cfg.halt;
endmodule

// File: rtl/aud_tx_serializer.sv
module aud_tx_serializer
  import aud_tx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              bitTick,
  input  logic              wsIn,
  output logic              wsOut,
  output logic              sdOut,
  output logic              fifoRdEn,
  input  logic [DATA_W-1:0] fifoRdData,
  input  logic              fifoEmpty,
  output logic              fifoClear,
  output logic              underrun
);
  cfg_t    cfg;
  strobe_t stb;
  logic    chanRstN;

  assign chanRstN  = rstN & ~cfg.clear;
  assign fifoClear = cfg.clear;
  assign fifoRdEn  = stb.fetch;

  aud_tx_cfg uCfg (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .wrData(cfgWrData), .cfg(cfg)
  );

  aud_tx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .chanRstN(chanRstN), .bitTick(bitTick), .cfg(cfg),
    .wsIn(wsIn), .fifoEmpty(fifoEmpty), .wsOut(wsOut), .stb(stb)
  );

  aud_tx_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .chanRstN(chanRstN), .cfg(cfg), .stb(stb),
    .fifoRdData(fifoRdData), .sdOut(sdOut), .underrun(underrun)
  );
endmodule

// File: rtl/aud_tx_checker.sv
module aud_tx_checker
  import aud_tx_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic chanRstN,
  input cfg_t cfg,
  input logic bitTick,
  input logic wsOut,
  input logic sdOut,
  input logic fifoRdEn,
  input logic fifoEmpty,
  input logic underrun
);
  assert_ws_on_tick_R3: assert property (@(posedge clk) disable iff (!chanRstN)
    !bitTick |=> $stable(wsOut));

  assert_mute_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfg.mute |-> !sdOut);

  assert_stop_no_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfg.halt |-> !fifoRdEn);

  assert_underrun_single_R9: assert property (@(posedge clk) disable iff (!chanRstN)
    underrun |=> !underrun);

  assert_read_no_underrun_R9: assert property (@(posedge clk) disable iff (!chanRstN)
    fifoRdEn |=> !underrun);

  assert_clear_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !chanRstN |-> (wsOut && !sdOut && !fifoRdEn));

  assert_read_legal_R12: assert property (@(posedge clk) disable iff (!rstN)
    fifoRdEn |-> (bitTick && !fifoEmpty));
endmodule

bind aud_tx_serializer aud_tx_checker uChk (
  .clk(clk), .rstN(rstN), .chanRstN(chanRstN), .cfg(cfg), .bitTick(bitTick),
  .wsOut(wsOut), .sdOut(sdOut), .fifoRdEn(fifoRdEn), .fifoEmpty(fifoEmpty),
  .underrun(underrun)
);

// File: tb/aud_tx_serializer_test.sv
module aud_tx_serializer_test;
  logic        clk = 0, rstN = 0, cfgWrEn = 0, bitTick = 0, wsIn = 1;
  logic [15:0] cfgWrData = '0;
  logic        wsOut, sdOut, fifoRdEn, fifoEmpty, fifoClear, underrun;
  logic [31:0] fifoRdData;

  logic [31:0] fifoMem [0:15];
  int fifoCnt = 0, readsTotal = 0, readBase = 0;
  int underTotal = 0, underDouble = 0, rdBad = 0;
  logic underPrev = 0;
  int checks = 0, fails = 0;
  int hLen = 31, wBits = 16;
  bit monoM = 0, zeroM = 0;

  always #4 clk = ~clk;

  aud_tx_serializer uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .bitTick(bitTick), .wsIn(wsIn), .wsOut(wsOut), .sdOut(sdOut),
    .fifoRdEn(fifoRdEn), .fifoRdData(fifoRdData), .fifoEmpty(fifoEmpty),
    .fifoClear(fifoClear), .underrun(underrun)
  );

  assign fifoEmpty  = (readsTotal - readBase) >= fifoCnt;
  assign fifoRdData = fifoEmpty ? 32'h0 : fifoMem[(readsTotal - readBase) & 15];

  always @(posedge clk) begin
    if (fifoRdEn) begin
      readsTotal <= readsTotal + 1;
      if (!bitTick || fifoEmpty) rdBad <= rdBad + 1;
    end
    if (underrun) begin
      underTotal <= underTotal + 1;
      if (underPrev) underDouble <= underDouble + 1;
    end
    underPrev <= underrun;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrCfg(input int code, input bit mono, input bit halt, input bit clr,
                       input bit slave, input bit mute, input int half);
    @(negedge clk);
    cfgWrEn   = 1;
    cfgWrData = {half[8:0], mute, slave, clr, halt, mono, code[1:0]};
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic restart(input int code, input bit mono, input bit halt,
                         input bit slave, input bit mute, input int half);
    wrCfg(code, mono, halt, 1, slave, mute, half);
    wrCfg(code, mono, halt, 0, slave, mute, half);
  endtask

  task automatic loadFifo(input int n, input logic [31:0] seed);
    for (int i = 0; i < 16; i++) fifoMem[i] = seed ^ (32'h9E3779B9 * (i + 1));
    fifoCnt  = n;
    readBase = readsTotal;
  endtask

  task automatic tickOnce();
    repeat (3) @(negedge clk);
    bitTick = 1;
    @(negedge clk);
    bitTick = 0;
  endtask

  function automatic bit modelWs(input int j);
    int m = j / (hLen + 1);
    return (m == 0) ? 1'b1 : ((m % 2) == 1 ? 1'b0 : 1'b1);
  endfunction

  function automatic bit modelBit(input int j);
    int m, i, idx;
    logic [31:0] w;
    m = (j - 1) / (hLen + 1);
    if (m == 0 || zeroM) return 1'b0;
    i   = j - (m * (hLen + 1) + 1);
    idx = monoM ? (m - 1) / 2 : (m - 1);
    if (i >= wBits || idx >= fifoCnt) return 1'b0;
    w = fifoMem[idx];
    return w[wBits - 1 - i];
  endfunction

  task automatic runCheck(input int n, input string req, input bit slaveDrive, input bit haltM);
    int ub = underTotal, db = underDouble, bb = rdBad;
    int nLoads, needed, expReads, expUnder;
    for (int j = 1; j <= n; j++) begin
      if (slaveDrive) wsIn = modelWs(j);
      tickOnce();
      chk(wsOut == modelWs(j) && sdOut == modelBit(j), req,
          $sformatf("tick %0d {ws,sd}", j), {wsOut, sdOut}, {modelWs(j), modelBit(j)});
    end
    repeat (2) @(negedge clk);
    nLoads   = (n - 1) / (hLen + 1);
    needed   = monoM ? (nLoads + 1) / 2 : nLoads;
    expReads = haltM ? 0 : (needed < fifoCnt ? needed : fifoCnt);
    expUnder = haltM ? 0 : (needed > fifoCnt ? needed - fifoCnt : 0);
    chk(readsTotal - readBase == expReads, {req, "/R12"}, "FIFO reads", readsTotal - readBase, expReads);
    chk(underTotal - ub == expUnder, {req, "/R9"}, "underrun pulses", underTotal - ub, expUnder);
    chk(underDouble == db, "R9", "underrun longer than 1 cycle", underDouble - db, 0);
    chk(rdBad == bb, "R12", "read off-tick or while empty", rdBad - bb, 0);
  endtask

  task automatic setModel(input int h, input int w, input bit mono, input bit zero);
    hLen = h; wBits = w; monoM = mono; zeroM = zero;
  endtask

  task automatic testReset();
    chk(wsOut == 1, "R1", "reset wsOut", wsOut, 1);
    chk(sdOut == 0, "R1", "reset sdOut", sdOut, 0);
    chk(fifoClear == 0 && underrun == 0, "R1", "reset flags", {fifoClear, underrun}, 0);
    wsIn = 0;
    tickOnce();
    chk(wsOut == 0, "R1", "default slave follows wsIn", wsOut, 0);
    chk(sdOut == 0, "R1", "default mute", sdOut, 0);
    wsIn = 1;
    tickOnce();
  endtask

  task automatic testStereo16();
    loadFifo(6, 32'h1234_A5C3);
    restart(1, 0, 0, 0, 0, 15);
    setModel(15, 16, 0, 0);
    runCheck(80, "R5", 0, 0);
  endtask

  task automatic testWidth8();
    loadFifo(6, 32'h0F0F_5A3C);
    restart(0, 0, 0, 0, 0, 7);
    setModel(7, 8, 0, 0);
    runCheck(40, "R2", 0, 0);
  endtask

  task automatic testWidth24();
    loadFifo(4, 32'hC001_D00D);
    restart(2, 0, 0, 0, 0, 31);
    setModel(31, 24, 0, 0);
    runCheck(97, "R2", 0, 0);
  endtask

  task automatic testWidth32Boundary();
    loadFifo(4, 32'h8000_0001);
    restart(3, 0, 0, 0, 0, 31);
    setModel(31, 32, 0, 0);
    runCheck(129, "R4", 0, 0);
  endtask

  task automatic testMono();
    loadFifo(3, 32'h7E57_0BAD);
    restart(1, 1, 0, 0, 0, 15);
    setModel(15, 16, 1, 0);
    runCheck(97, "R6", 0, 0);
  endtask

  task automatic testMute();
    loadFifo(4, 32'hFFFF_FFFF);
    restart(1, 0, 0, 0, 1, 15);
    setModel(15, 16, 0, 1);
    runCheck(65, "R7", 0, 0);
  endtask

  task automatic testStop();
    loadFifo(4, 32'hFFFF_FFFF);
    restart(1, 0, 1, 0, 0, 15);
    setModel(15, 16, 0, 1);
    runCheck(65, "R8", 0, 1);
  endtask

  task automatic testUnderrun();
    loadFifo(2, 32'h3C3C_C3C3);
    restart(1, 0, 0, 0, 0, 15);
    setModel(15, 16, 0, 0);
    runCheck(65, "R9", 0, 0);
  endtask

  task automatic testSlave();
    wsIn = 1;
    loadFifo(5, 32'h5115_AE00);
    restart(0, 0, 0, 1, 0, 31);
    setModel(9, 8, 0, 0);
    runCheck(51, "R10", 1, 0);
    wsIn = 1;
  endtask

  task automatic testMasterWs();
    loadFifo(8, 32'h0000_0000);
    restart(0, 0, 0, 0, 0, 3);
    setModel(3, 8, 0, 0);
    runCheck(33, "R3", 0, 0);
  endtask

  task automatic testClear();
    int rd;
    loadFifo(8, 32'hABCD_0123);
    restart(0, 0, 0, 0, 0, 7);
    setModel(7, 8, 0, 0);
    runCheck(20, "R11", 0, 0);
    wrCfg(0, 0, 0, 1, 0, 0, 7);
    chk(fifoClear == 1, "R11", "fifoClear", fifoClear, 1);
    chk(wsOut == 1 && sdOut == 0, "R11", "{ws,sd} in clear", {wsOut, sdOut}, 2);
    rd = readsTotal;
    for (int k = 0; k < 12; k++) tickOnce();
    chk(wsOut == 1 && sdOut == 0, "R11", "{ws,sd} held", {wsOut, sdOut}, 2);
    chk(readsTotal == rd, "R11", "reads during clear", readsTotal - rd, 0);
    loadFifo(8, 32'h1357_9BDF);
    wrCfg(0, 0, 0, 0, 0, 0, 7);
    runCheck(40, "R11", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testStereo16();
    testWidth8();
    testWidth24();
    testWidth32Boundary();
    testMono();
    testMute();
    testStop();
    testUnderrun();
    testSlave();
    testMasterWs();
    testClear();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule